// File: doc/BRIEF.md
# Integer ALU Execute Stage

This block is the execute stage for the integer register-register and register-immediate instruction groups of a 32-bit load/store processor. Each cycle it takes an instruction word, the two source register values and an immediate that has already been sign-extended. It computes the arithmetic, shift, compare or bitwise result. At the next clock edge it presents that result in an output register, together with the destination register index and a write-enable for the register file.

The operation comes from the 3-bit function field in instruction bits 14:12. Instruction bit 30 modifies two of the operations. The opcode in bits 6:0 picks the second operand: the immediate or the second register value. An opcode outside the two supported groups produces no write and raises an illegal-operation flag. The decode, the barrel shifter and the magnitude comparator are separate submodules. The top module holds one output register.

Top module: `int_exec_stage`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, the outputs read zero: result, destination index, write-enable and illegal flag.
- R2: Opcode 0x33 takes the second operand from `rs2_i`. Opcode 0x13 takes it from `imm_i`. Function code 0 adds the two operands, modulo 2^32.
- R3: Function code 0 with instruction bit 30 set subtracts (first minus second) only for opcode 0x33. For opcode 0x13, bit 30 is ignored and the result is the sum.
- R4: Function code 1 shifts the first operand left, filling with zeros. The shift amount is the low 5 bits of the second operand, and its upper bits are ignored.
- R5: Function code 5 shifts right by the low 5 bits of the second operand, in both forms. With instruction bit 30 set the vacated bits copy bit 31. With bit 30 clear they are zeros.
- R6: Function code 2 compares the operands as signed two's-complement numbers. Function code 3 compares them as unsigned numbers. The result is exactly 1 when the first operand is less than the second, and 0 otherwise.
- R7: Function codes 4, 6 and 7 give the bitwise XOR, OR and AND of the two operands.
- R8: `rd_o` carries instruction bits 11:7. `wr_en_o` is low whenever that index is 0, whatever the operation.
- R9: Any opcode other than 0x13 or 0x33 gives `illegal_o` = 1, `wr_en_o` = 0 and a zero result. A supported opcode gives `illegal_o` = 0.
- R10: Outputs change only at a rising clock edge and reflect the inputs present at that edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | XLEN | First source register value |
| rs2_i | input | XLEN | Second source register value |
| imm_i | input | XLEN | Sign-extended immediate |
| result_o | output | XLEN | Registered result |
| rd_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered register-file write-enable |
| illegal_o | output | 1 | Registered unsupported-opcode flag |

## Verification
The arithmetic right shift is the hardest path to reach with telling values. A sign fill only shows when bit 31 is set and the shift amount is non-zero. The masking of the amount only shows when bits above bit 4 of the operand are set. The table therefore drives negative operands with amounts such as 0x24 and 0x404, as well as the extreme shift of 31. The signed and unsigned compares are driven with operand pairs that straddle the sign boundary, where the two orderings disagree. After the table, a few hundred random instructions compare every function code in both forms against a model in the bench that is written from the requirements.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int          INSTR_W = 32;
    localparam int          RD_W    = 5;
    localparam logic [6:0]  OPC_IMM = 7'h13;
    localparam logic [6:0]  OPC_REG = 7'h33;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND
    } alu_op_e;

    typedef struct packed {
        alu_op_e           op;
        logic              use_imm;
        logic              legal;
        logic [RD_W-1:0]   rd;
    } dec_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);

    logic [6:0] opcode;
    logic [2:0] fn;
    logic       mod_bit;

    always_comb begin
        opcode        = instr_i[6:0];
        fn            = instr_i[14:12];
        mod_bit       = instr_i[30];
        dec_o.rd      = instr_i[11:7];
        dec_o.use_imm = (opcode == OPC_IMM);
        dec_o.legal   = (opcode == OPC_IMM) || (opcode == OPC_REG);
        unique case (fn)
            3'd0:    dec_o.op = (mod_bit && opcode == OPC_REG) ? ALU_SUB : ALU_ADD;
            3'd1:    dec_o.op = ALU_SLL;
            3'd2:    dec_o.op = ALU_SLT;
            3'd3:    dec_o.op = ALU_SLTU;
            3'd4:    dec_o.op = ALU_XOR;
            3'd5:    dec_o.op = mod_bit ? ALU_SRA : ALU_SRL;
            3'd6:    dec_o.op = ALU_OR;
            default: dec_o.op = ALU_AND;
        endcase
    end

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] data_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic            left_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] data_o
);

    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    // Left shifts reuse the right-shift network on bit-reversed data.
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign rev_in[i]  = data_i[XLEN-1-i];
        assign rev_out[i] = stage[SHW][XLEN-1-i];
    end

    assign fill     = arith_i & ~left_i & data_i[XLEN-1];
    assign stage[0] = left_i ? rev_in : data_i;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stage[g+1] = shamt_i[g] ? {{STEP{fill}}, stage[g][XLEN-1:STEP]}
                                       : stage[g];
    end

    assign data_o = left_i ? rev_out : stage[SHW];

endmodule

// File: rtl/exec_compare.sv
module exec_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            signed_i,
    output logic            lt_o
);

    logic [XLEN:0] diff;
    logic          borrow;

    always_comb begin
        diff   = {1'b0, a_i} - {1'b0, b_i};
        borrow = diff[XLEN];
        if (signed_i && (a_i[XLEN-1] != b_i[XLEN-1]))
            lt_o = a_i[XLEN-1];
        else
            lt_o = borrow;
    end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [XLEN-1:0]     rs1_i,
    input  logic [XLEN-1:0]     rs2_i,
    input  logic [XLEN-1:0]     imm_i,
    output logic [XLEN-1:0]     result_o,
    output logic [RD_W-1:0]     rd_o,
    output logic                wr_en_o,
    output logic                illegal_o
);

    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [RD_W-1:0] rd;
        logic            wr_en;
        logic            illegal;
    } out_t;

    dec_t            dec;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] shift_res;
    logic            lt;
    out_t            out_d;
    out_t            out_q;

    exec_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign opb = dec.use_imm ? imm_i : rs2_i;

    exec_shifter #(.XLEN(XLEN)) u_shift (
        .data_i  (rs1_i),
        .shamt_i (opb[SHW-1:0]),
        .left_i  (dec.op == ALU_SLL),
        .arith_i (dec.op == ALU_SRA),
        .data_o  (shift_res)
    );

    exec_compare #(.XLEN(XLEN)) u_cmp (
        .a_i      (rs1_i),
        .b_i      (opb),
        .signed_i (dec.op == ALU_SLT),
        .lt_o     (lt)
    );

    always_comb begin
        out_d.rd      = dec.rd;
        out_d.illegal = ~dec.legal;
        out_d.wr_en   = dec.legal && (dec.rd != '0);
        unique case (dec.op)
            ALU_ADD:            out_d.result = rs1_i + opb;
            ALU_SUB:            out_d.result = rs1_i - opb;
            ALU_SLL,
            ALU_SRL,
            ALU_SRA:            out_d.result = shift_res;
            ALU_SLT,
            ALU_SLTU:           out_d.result = {{(XLEN-1){1'b0}}, lt};
            ALU_XOR:            out_d.result = rs1_i ^ opb;
            ALU_OR:             out_d.result = rs1_i | opb;
            default:            out_d.result = rs1_i & opb;
        endcase
        if (!dec.legal)
            out_d.result = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign result_o  = out_q.result;
    assign rd_o      = out_q.rd;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;

endmodule

// File: rtl/int_exec_stage_chk.sv
module int_exec_stage_chk #(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      instr_i,
    input logic [XLEN-1:0]  rs1_i,
    input logic [XLEN-1:0]  rs2_i,
    input logic [XLEN-1:0]  result_o,
    input logic [4:0]       rd_o,
    input logic             wr_en_o,
    input logic             illegal_o
);

    localparam int SHW = $clog2(XLEN);

    logic supported;
    assign supported = (instr_i[6:0] == 7'h13) || (instr_i[6:0] == 7'h33);

    // R8
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[11:7] == 5'd0) |=> !wr_en_o);

    // R8
    rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_o == $past(instr_i[11:7])));

    // R9
    bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supported |=> (illegal_o && !wr_en_o && result_o == '0));

    // R9
    good_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supported && instr_i[11:7] != 5'd0) |=> (wr_en_o && !illegal_o));

    // R6
    slt_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supported && (instr_i[14:12] == 3'd2 || instr_i[14:12] == 3'd3))
        |=> (result_o[XLEN-1:1] == '0));

    // R4
    sll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[6:0] == 7'h33 && instr_i[14:12] == 3'd1 && rs2_i[SHW-1:0] == '0)
        |=> (result_o == $past(rs1_i)));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, illegal_o}));

endmodule

bind int_exec_stage int_exec_stage_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .result_o  (result_o),
    .rd_o      (rd_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o)
);

// File: tb/int_exec_stage_test.sv
module int_exec_stage_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic [31:0] rs1;
    logic [31:0] rs2;
    logic [31:0] imm;
    logic [31:0] result;
    logic [4:0]  rd;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    int_exec_stage #(.XLEN(32)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .rs1_i     (rs1),
        .rs2_i     (rs2),
        .imm_i     (imm),
        .result_o  (result),
        .rd_o      (rd),
        .wr_en_o   (wr_en),
        .illegal_o (illegal)
    );

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] f3,
                                       input logic b30, input logic [4:0] d);
        return {1'b0, b30, 15'h0, f3, d, opc};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] im;
        logic [31:0] res;
        logic        we;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{mk(7'h33,3'd0,1'b0,5'd3),  32'd5, 32'd7, 32'd0, 32'd12, 1'b1, 1'b0, 4'd2},               // R2 add
        '{mk(7'h33,3'd0,1'b1,5'd3),  32'd5, 32'd7, 32'd0, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd3},         // R3 sub
        '{mk(7'h13,3'd0,1'b1,5'd4),  32'd5, 32'h99, 32'd3, 32'd8, 1'b1, 1'b0, 4'd3},               // R3 imm ignores bit 30
        '{mk(7'h33,3'd1,1'b0,5'd5),  32'd1, 32'h23, 32'd0, 32'd8, 1'b1, 1'b0, 4'd4},               // R4 masked amount
        '{mk(7'h33,3'd5,1'b0,5'd6),  32'h80000000, 32'd4, 32'd0, 32'h08000000, 1'b1, 1'b0, 4'd5},  // R5 logical
        '{mk(7'h33,3'd5,1'b1,5'd6),  32'h80000000, 32'h24, 32'd0, 32'hF8000000, 1'b1, 1'b0, 4'd5}, // R5 arith
        '{mk(7'h13,3'd5,1'b1,5'd7),  32'hF0000000, 32'd0, 32'h404, 32'hFF000000, 1'b1, 1'b0, 4'd5},// R5 imm arith
        '{mk(7'h33,3'd2,1'b0,5'd8),  32'hFFFFFFFF, 32'd1, 32'd0, 32'd1, 1'b1, 1'b0, 4'd6},         // R6 signed
        '{mk(7'h33,3'd3,1'b0,5'd8),  32'hFFFFFFFF, 32'd1, 32'd0, 32'd0, 1'b1, 1'b0, 4'd6},         // R6 unsigned
        '{mk(7'h13,3'd2,1'b0,5'd9),  32'd0, 32'd0, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0, 4'd6},         // R6 imm signed
        '{mk(7'h13,3'd3,1'b0,5'd9),  32'd0, 32'd0, 32'hFFFFFFFF, 32'd1, 1'b1, 1'b0, 4'd6},         // R6 imm unsigned
        '{mk(7'h33,3'd4,1'b0,5'd10), 32'hF0F0F0F0, 32'hFF00FF00, 32'd0, 32'h0FF00FF0, 1'b1, 1'b0, 4'd7}, // R7 xor
        '{mk(7'h13,3'd6,1'b0,5'd11), 32'h0F, 32'hB0, 32'hF0, 32'hFF, 1'b1, 1'b0, 4'd7},            // R7 or
        '{mk(7'h33,3'd7,1'b0,5'd12), 32'h12345678, 32'h0000FFFF, 32'd0, 32'h5678, 1'b1, 1'b0, 4'd7}, // R7 and
        '{mk(7'h33,3'd0,1'b0,5'd0),  32'd5, 32'd7, 32'd0, 32'd12, 1'b0, 1'b0, 4'd8},               // R8 x0
        '{mk(7'h03,3'd0,1'b0,5'd3),  32'd5, 32'd7, 32'd0, 32'd0, 1'b0, 1'b1, 4'd9},                // R9 illegal
        '{mk(7'h33,3'd5,1'b1,5'd13), 32'h80000000, 32'h1F, 32'd0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd5}, // R5 by 31
        '{mk(7'h13,3'd1,1'b0,5'd14), 32'hDEADBEEF, 32'd0, 32'h20, 32'hDEADBEEF, 1'b1, 1'b0, 4'd4}, // R4 amount 0
        '{mk(7'h33,3'd2,1'b0,5'd15), 32'h7FFFFFFF, 32'h80000000, 32'd0, 32'd0, 1'b1, 1'b0, 4'd6},  // R6 boundary
        '{mk(7'h33,3'd3,1'b0,5'd15), 32'h7FFFFFFF, 32'h80000000, 32'd0, 32'd1, 1'b1, 1'b0, 4'd6}   // R6 boundary
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model written from R2..R9
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, output logic [31:0] res,
                         output logic we, output logic ill);
        logic        is_imm = (ins[6:0] == 7'h13);
        logic        ok     = is_imm || (ins[6:0] == 7'h33);
        logic [31:0] y      = is_imm ? im : b;
        logic [4:0]  sh     = y[4:0];
        case (ins[14:12])
            3'd0: res = (ins[30] && !is_imm) ? a - y : a + y;
            3'd1: res = a << sh;
            3'd2: res = ($signed(a) < $signed(y)) ? 32'd1 : 32'd0;
            3'd3: res = (a < y) ? 32'd1 : 32'd0;
            3'd4: res = a ^ y;
            3'd5: res = ins[30] ? 32'($signed(a) >>> sh) : a >> sh;
            3'd6: res = a | y;
            default: res = a & y;
        endcase
        if (!ok) res = 32'd0;
        we  = ok && (ins[11:7] != 5'd0);
        ill = !ok;
    endtask

    initial begin
        logic [31:0] er;
        logic        ew, ei;
        rst_n = 1'b0; instr = 32'h0; rs1 = 32'h0; rs2 = 32'h0; imm = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(result == 32'd0, "R1", "result in reset", result, 32'd0);
        chk({wr_en, illegal, rd} == 7'd0, "R1", "flags in reset", {25'd0, wr_en, illegal, rd}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            instr = TBL[i].ins; rs1 = TBL[i].a; rs2 = TBL[i].b; imm = TBL[i].im;
            @(negedge clk);
            chk(result == TBL[i].res, $sformatf("R%0d", TBL[i].req), $sformatf("vector %0d result", i),
                result, TBL[i].res);
            chk(wr_en == TBL[i].we && illegal == TBL[i].ill, $sformatf("R%0d", TBL[i].req),
                $sformatf("vector %0d we/ill", i), {30'd0, wr_en, illegal}, {30'd0, TBL[i].we, TBL[i].ill});
            chk(rd == TBL[i].ins[11:7], "R8", $sformatf("vector %0d rd", i), {27'd0, rd}, {27'd0, TBL[i].ins[11:7]});
        end

        // R10: new inputs do not reach the outputs before the next edge
        instr = mk(7'h33, 3'd0, 1'b0, 5'd2); rs1 = 32'd100; rs2 = 32'd1;
        @(negedge clk);
        instr = mk(7'h33, 3'd4, 1'b0, 5'd9); rs1 = 32'hAAAA0000; rs2 = 32'h0000AAAA;
        #2;
        chk(result == 32'd101 && rd == 5'd2, "R10", "held before edge", result, 32'd101);
        @(negedge clk);
        chk(result == 32'hAAAAAAAA && rd == 5'd9, "R10", "captured at edge", result, 32'hAAAAAAAA);

        // R1: asynchronous reset mid-run clears the outputs
        rst_n = 1'b0;
        #1;
        chk(result == 32'd0 && !wr_en && rd == 5'd0, "R1", "async reset", result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Random instructions in both forms against the model (R2..R9)
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w = $urandom;
            w[6:0] = (k % 17 == 0) ? 7'h6F : ((k % 2 == 0) ? 7'h13 : 7'h33);
            instr = w; rs1 = $urandom; rs2 = $urandom; imm = $urandom;
            if (k % 5 == 0) rs1[31] = 1'b1;
            model(instr, rs1, rs2, imm, er, ew, ei);
            @(negedge clk);
            chk(result == er, "R2-model", $sformatf("random %0d instr %h result", k, instr), result, er);
            chk(wr_en == ew && illegal == ei, "R9", $sformatf("random %0d flags", k),
                {30'd0, wr_en, illegal}, {30'd0, ew, ei});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule